// File: doc/BRIEF.md
# Idle Mode Entry and Wake Controller

This controller decides when a CPU core stops its clock for a low-power idle state and when it starts it again. Software asks for idle by writing 1 to a request bit. If no enabled interrupt is waiting at that moment, the controller records which run speed (normal or slow) was active. It then drops the CPU clock enable and waits. The peripheral clock and all held state are outside this block and stay untouched.

While idle, the controller watches every interrupt latch ANDed with its own enable flag. The first enabled latch that is set ends the idle state. The CPU clock comes back in the run speed that was saved at entry. The global interrupt enable decides how the core resumes. When it is 0, the core simply continues at the next instruction, and software clears the latch itself. When it is 1, the controller emits a one-cycle vector-take strobe, so that the core services the interrupt first. A reset ends any state and starts a warm-up phase. The external warm-up counter signals its end, and the controller then enters normal run speed.

Top module: `idle_wake_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the mode is WARMUP (code 3), the CPU clock enable is 0, the request bit reads 0 and the vector strobe is 0. A reset also ends the idle state.
- R2: The mode stays WARMUP until warm-up done is sampled high on a clock edge. After that edge the mode is RUN_NORMAL (code 0).
- R3: In a run mode (codes 0 and 1), a speed write selects RUN_SLOW (code 1) when its data bit is 1 and RUN_NORMAL (code 0) when it is 0. The CPU clock enable is 1 in both run modes.
- R4: A request write with data 1 in a run mode, while no enabled latch is set, moves the mode to IDLE (code 2) after the edge. In IDLE the CPU clock enable is 0 and the request bit reads 1. A speed write in the same cycle is ignored.
- R5: A request write with data 1 is refused when any latch and its enable bit are both 1 in that same cycle. The mode is unchanged and the request bit stays 0.
- R6: In IDLE, latches whose enable bit is 0 do not end the idle state.
- R7: In IDLE, any latch with its enable set ends the state at the next edge. The mode returns to the run speed saved at entry, and the request bit reads 0.
- R8: A wake with the global interrupt enable at 0 produces no vector strobe.
- R9: A wake with the global interrupt enable at 1 produces a vector strobe for exactly one cycle. That cycle is the first one back in run mode.
- R10: A request write with data 0, and any speed or request write during IDLE or WARMUP, has no effect on the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (any reset source) |
| req_wr | input | 1 | Write strobe for the idle request bit |
| req_wdata | input | 1 | Data written to the idle request bit |
| speed_wr | input | 1 | Write strobe for the run speed select |
| speed_slow | input | 1 | Run speed data: 1 slow, 0 normal |
| irq_latch | input | NUM_IRQ | Interrupt latches |
| irq_enable | input | NUM_IRQ | Individual interrupt enable flags |
| ime | input | 1 | Global interrupt master enable |
| warmup_done | input | 1 | Warm-up counter finished |
| cpu_clk_en | output | 1 | CPU clock enable |
| vec_take | output | 1 | One-cycle strobe to service the waking interrupt |
| idle_req | output | 1 | Request bit readback |
| mode | output | 2 | Current mode code |

## Verification
The hardest case to reach from the ports is a request that races an interrupt. An enabled latch has to rise in exactly the cycle of the request write, while a disabled latch may be set at the same time. Directed steps set up that cycle on purpose, and they also set up one where only disabled latches are active. A seeded random phase then makes enabled latches rare. This lets idle periods last many cycles and makes the race arise by chance as well. Every result is compared against a cycle model kept in the bench.

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl #(
  parameter int NUM_IRQ = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_wr,
  input  logic               req_wdata,
  input  logic               speed_wr,
  input  logic               speed_slow,
  input  logic [NUM_IRQ-1:0] irq_latch,
  input  logic [NUM_IRQ-1:0] irq_enable,
  input  logic               ime,
  input  logic               warmup_done,
  output logic               cpu_clk_en,
  output logic               vec_take,
  output logic               idle_req,
  output logic [1:0]         mode
);
  localparam logic [1:0] RUN_NORMAL = 2'd0;
  localparam logic [1:0] RUN_SLOW   = 2'd1;
  localparam logic [1:0] IDLE       = 2'd2;
  localparam logic [1:0] WARMUP     = 2'd3;

  logic [1:0] mode_q;
  logic       saved_slow_q;
  logic       vec_q;
  logic       wake_pending;
  logic       in_run;
  logic       enter;

  assign wake_pending = |(irq_latch & irq_enable);
  assign in_run       = ~mode_q[1];
  assign enter        = in_run & req_wr & req_wdata & ~wake_pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= WARMUP;
      saved_slow_q <= 1'b0;
      vec_q        <= 1'b0;
    end else begin
      vec_q <= 1'b0;
      case (mode_q)
        WARMUP: if (warmup_done) mode_q <= RUN_NORMAL;
        IDLE: if (wake_pending) begin
          mode_q <= saved_slow_q ? RUN_SLOW : RUN_NORMAL;
          vec_q  <= ime;
        end
        default: begin
          if (enter) begin
            mode_q       <= IDLE;
            saved_slow_q <= mode_q[0];
          end else if (speed_wr) begin
            mode_q <= speed_slow ? RUN_SLOW : RUN_NORMAL;
          end
        end
      endcase
    end
  end

  assign mode       = mode_q;
  assign cpu_clk_en = in_run;
  assign idle_req   = (mode_q == IDLE);
  assign vec_take   = vec_q;

  assert_warmup_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == WARMUP && warmup_done) |=> (mode == RUN_NORMAL));

  assert_enter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_req) |-> $past(req_wr && req_wdata && cpu_clk_en));

  assert_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en && req_wr && wake_pending) |=> !idle_req);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && !wake_pending) |=> idle_req);

  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && wake_pending) |=> (cpu_clk_en && !idle_req));

  assert_no_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_req && wake_pending && !ime) |=> !vec_take);

  assert_vec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |=> !vec_take);

  assert_vec_origin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_take |-> $past(idle_req && ime));
endmodule

// File: tb/idle_wake_ctrl_test.sv
module idle_wake_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_wr = 0, req_wdata = 0, speed_wr = 0, speed_slow = 0, ime = 0, warmup_done = 0;
  logic [N-1:0] irq_latch = '0, irq_enable = '0;
  logic cpu_clk_en, vec_take, idle_req;
  logic [1:0] mode;

  int tests = 0, fails = 0;
  logic [1:0] m_mode = 2'd3;
  logic m_saved = 1'b0, m_vec = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idle_wake_ctrl #(.NUM_IRQ(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_wdata(req_wdata),
    .speed_wr(speed_wr), .speed_slow(speed_slow), .irq_latch(irq_latch),
    .irq_enable(irq_enable), .ime(ime), .warmup_done(warmup_done),
    .cpu_clk_en(cpu_clk_en), .vec_take(vec_take), .idle_req(idle_req), .mode(mode));

  function automatic logic [4:0] expect_outs(logic [1:0] md, logic vc);
    return {md, md < 2'd2, md == 2'd2, vc};
  endfunction

  task automatic check(string tag);
    logic [4:0] got, exp;
    got = {mode, cpu_clk_en, idle_req, vec_take};
    exp = expect_outs(m_mode, m_vec);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: {mode,clk_en,req,vec} actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic model_step();
    logic pend;
    pend = |(irq_latch & irq_enable);
    m_vec = 1'b0;
    if (m_mode == 2'd3) begin
      if (warmup_done) m_mode = 2'd0;
    end else if (m_mode == 2'd2) begin
      if (pend) begin m_mode = {1'b0, m_saved}; m_vec = ime; end
    end else if (req_wr && req_wdata && !pend) begin
      m_saved = m_mode[0]; m_mode = 2'd2;
    end else if (speed_wr) begin
      m_mode = {1'b0, speed_slow};
    end
  endtask

  task automatic tick(string tag);
    model_step();
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle_inputs();
    req_wr = 0; req_wdata = 0; speed_wr = 0; speed_slow = 0;
    warmup_done = 0; irq_latch = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    m_mode = 2'd3; m_saved = 1'b0; m_vec = 1'b0;
    check("R1 reset");
    @(negedge clk);
    check("R1 reset held");
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();
    speed_wr = 1; speed_slow = 1; req_wr = 1; req_wdata = 1;
    tick("R10 writes in warmup");
    idle_inputs();
    tick("R2 waiting");
    warmup_done = 1;
    tick("R2 exit");
    idle_inputs();
    speed_wr = 1; speed_slow = 1;
    tick("R3 slow");
    speed_slow = 0;
    tick("R3 normal");
    speed_wr = 0; req_wr = 1; req_wdata = 0;
    tick("R10 write zero");
    req_wdata = 1; speed_wr = 1; speed_slow = 1;
    tick("R4 enter normal");
    idle_inputs();
    req_wr = 1; req_wdata = 1; speed_wr = 1; speed_slow = 1;
    tick("R10 writes in idle");
    idle_inputs();
    irq_enable = 8'h0F; irq_latch = 8'hF0;
    tick("R6 disabled latch");
    tick("R6 still idle");
    ime = 0; irq_latch = 8'h04;
    tick("R7 R8 wake plain");
    irq_latch = '0; speed_wr = 1; speed_slow = 1;
    tick("R3 to slow");
    speed_wr = 0; req_wr = 1; req_wdata = 1; irq_latch = 8'h01;
    tick("R5 refused");
    irq_latch = 8'h80;
    tick("R4 enter slow, disabled latch");
    idle_inputs();
    ime = 1; irq_latch = 8'h02;
    tick("R7 R9 wake slow vectored");
    irq_latch = '0;
    tick("R9 pulse ends");
    req_wr = 1; req_wdata = 1;
    tick("R4 enter again");
    idle_inputs();
    @(negedge clk);
    do_reset();
    tick("R1 reset ended idle");
    warmup_done = 1;
    tick("R2 exit again");

    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      req_wr = ($urandom % 6) == 0;
      req_wdata = ($urandom % 4) != 0;
      speed_wr = ($urandom % 8) == 0;
      speed_slow = $urandom % 2;
      warmup_done = ($urandom % 3) == 0;
      ime = $urandom % 2;
      irq_enable = N'($urandom);
      irq_latch = (($urandom % 10) == 0) ? N'($urandom) : '0;
      if (($urandom % 500) == 0) begin
        do_reset();
      end else begin
        tick("R3 R4 R5 R7 R9 random");
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule